// File: doc/BRIEF.md
# Line Pulse Density Monitor

This block checks a received serial line stream, one bit for each clock on which the bit-valid input is high, against the ones-density rule used on T1-type lines. It raises a live violation state in two cases. The first is a run of zeros longer than the allowed limit. The second is any sliding window of 8·(N+1) bits, once that many bits have arrived, that holds fewer than N ones. With the default N = 23 the window is 192 bits long and must hold at least 23 ones.

Next to the live state the block keeps a sticky status bit, which also drives the interrupt line. A mode input chooses when that bit is set. In one setting it is set on every change of the live state. In the other it is set only when a violation begins. A status-read strobe clears the bit. Line decoding, framing and the processor bus live outside this block.

Top module: `line_density_mon`

## Requirements
- R1: After a synchronous active-low reset, dens_state, dens_status and dens_irq are all 0.
- R2: Receiving the 16th consecutive zero bit (a run of more than 15 zeros) drives dens_state to 1 on the clock edge that takes that bit.
- R3: A received one ends the zero run at once. The zero-run count saturates and does not wrap, so dens_state stays 1 for as long as a zero run of any length continues.
- R4: Once at least 192 valid bits have been received, dens_state is 1 after a bit whenever the last 192 valid bits hold fewer than 23 ones. The window slides one bit at a time. Exactly 23 ones is not a violation.
- R5: Before 192 valid bits have been received since reset, the window rule is not applied and only the zero-run rule can set dens_state.
- R6: dens_state is the OR of the two rules and changes only on the edge of a cycle with bit_vld = 1. Cycles with bit_vld = 0 are ignored whatever bit_in holds.
- R7: With chg_mode = 1, dens_status is set on every change of dens_state, both 0 to 1 and 1 to 0.
- R8: With chg_mode = 0, dens_status is set only when dens_state goes from 0 to 1. A 1 to 0 change leaves it unchanged.
- R9: A cycle with stat_rd = 1 clears dens_status on its edge. If a set event happens in the same cycle, the set wins and dens_status is 1.
- R10: dens_irq always equals dens_status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | bit_in carries a received line bit this cycle |
| bit_in | input | 1 | Received data bit |
| chg_mode | input | 1 | 1: status set on every state change; 0: only on entry into violation |
| stat_rd | input | 1 | Status read strobe, clears the sticky status |
| dens_state | output | 1 | Live density violation state |
| dens_status | output | 1 | Sticky violation status, cleared by read |
| dens_irq | output | 1 | Interrupt line, follows dens_status |

## Verification
A wrong zero-run count shows on dens_state at the edge of the 16th zero, or at the first one after a long run. A wrong ones count or a wrong fill count shows at the 192nd bit, or at the first bit later on where the true window count crosses 23. Errors in the status logic show one edge after a state change or a read. The bench compares all three outputs after every driven cycle against a model that keeps its own 192-bit history, so a divergence is reported on the cycle it first reaches a port.

// File: rtl/pdm_pkg.sv
// Shared defaults for the line pulse density monitor.
// Assumes the window length rule 8*(N+1) for a minimum of N ones.
package pdm_pkg;
    localparam int unsigned PDM_MIN_ONES = 23;
    localparam int unsigned PDM_ZRUN_MAX = 15;

    // Window length in bits for a given minimum ones count.
    function automatic int unsigned pdm_win_len(input int unsigned min_ones);
        return 8 * (min_ones + 1);
    endfunction
endpackage

// File: rtl/pdm_zero_run.sv
// Zero-run tracker: counts consecutive valid zero bits, saturating one above
// the allowed maximum. It gives the run condition as it will be once the
// current bit is included. Assumes bit_in matters only when bit_vld is high.
module pdm_zero_run #(
    parameter int unsigned ZRUN_MAX = pdm_pkg::PDM_ZRUN_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic run_viol_nxt
);
    localparam int unsigned ZW = $clog2(ZRUN_MAX + 2);
    localparam logic [ZW-1:0] SAT = ZW'(ZRUN_MAX + 1);

    logic [ZW-1:0] zrun_q, zrun_nxt;

    // Next run length: cleared by a one, saturating increment on a zero.
    always_comb begin
        zrun_nxt = zrun_q;
        if (bit_vld) begin
            if (bit_in)
                zrun_nxt = '0;
            else if (zrun_q != SAT)
                zrun_nxt = zrun_q + 1'b1;
        end
    end

    // Run length register.
    always_ff @(posedge clk) begin
        if (!rst_n) zrun_q <= '0;
        else        zrun_q <= zrun_nxt;
    end

    assign run_viol_nxt = (zrun_nxt > ZW'(ZRUN_MAX));

    // R3: the count never passes the saturation point.
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        zrun_q <= SAT);
    // R3: a received one empties the run.
    a_r3_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in) |=> (zrun_q == '0));
endmodule

// File: rtl/pdm_window.sv
// Sliding-window ones counter: keeps the last WIN_LEN valid bits and a
// running count of the ones among them. It gives the window condition as it
// will be once the current bit is included. The rule applies only once the
// window has been filled since reset.
module pdm_window #(
    parameter int unsigned MIN_ONES = pdm_pkg::PDM_MIN_ONES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic dens_viol_nxt
);
    localparam int unsigned WIN_LEN = pdm_pkg::pdm_win_len(MIN_ONES);
    localparam int unsigned CW = $clog2(WIN_LEN + 1);
    localparam logic [CW-1:0] WIN_C = CW'(WIN_LEN);
    localparam logic [CW-1:0] MIN_C = CW'(MIN_ONES);

    logic [WIN_LEN-1:0] hist_q;
    logic [CW-1:0]      ones_q, ones_nxt;
    logic [CW-1:0]      fill_q, fill_nxt;
    logic               leave_bit;

    // Bit dropping out of the window, meaningful only once it is full.
    assign leave_bit = (fill_q == WIN_C) ? hist_q[WIN_LEN-1] : 1'b0;

    // Next ones count and next fill level.
    always_comb begin
        ones_nxt = ones_q;
        fill_nxt = fill_q;
        if (bit_vld) begin
            ones_nxt = ones_q + CW'(bit_in) - CW'(leave_bit);
            if (fill_q != WIN_C) fill_nxt = fill_q + 1'b1;
        end
    end

    // History shift register, ones count and fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            ones_q <= '0;
            fill_q <= '0;
        end else begin
            if (bit_vld) hist_q <= {hist_q[WIN_LEN-2:0], bit_in};
            ones_q <= ones_nxt;
            fill_q <= fill_nxt;
        end
    end

    assign dens_viol_nxt = (fill_nxt == WIN_C) && (ones_nxt < MIN_C);

    // R4: the running count agrees with the stored history.
    a_r4_count_match: assert property (@(posedge clk) disable iff (!rst_n)
        ones_q == CW'($countones(hist_q)));
    // R5: the fill level never runs past the window length.
    a_r5_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= WIN_C);
endmodule

// File: rtl/pdm_irq_latch.sv
// Sticky status: turns changes of the live state into set events according
// to the mode, and holds the result until a read. A set event beats a read
// in the same cycle.
module pdm_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic chg_mode,
    input  logic viol_cur,
    input  logic viol_nxt,
    input  logic stat_rd,
    output logic status
);
    logic set_ev;

    // Set event: any change in change mode, entry only otherwise.
    assign set_ev = bit_vld && (viol_nxt != viol_cur) && (chg_mode || viol_nxt);

    // Status register: set has priority over clear-on-read.
    always_ff @(posedge clk) begin
        if (!rst_n)       status <= 1'b0;
        else if (set_ev)  status <= 1'b1;
        else if (stat_rd) status <= 1'b0;
    end

    // R9: a set in the same cycle as a read still leaves the status set.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_cur != viol_nxt && bit_vld && (chg_mode || viol_nxt)) |=> status);
    // R9: a read with no set event clears the status.
    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(bit_vld && viol_cur != viol_nxt)) |=> !status);
    // R8: leaving violation in entry-only mode never sets the status.
    a_r8_no_exit_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!status && !chg_mode && viol_cur && !viol_nxt) |=> !status);
endmodule

// File: rtl/line_density_mon.sv
// Line pulse density monitor top: combines the zero-run rule and the sliding
// window rule into a live state, updated only on valid bits, and feeds the
// sticky status that drives the interrupt line.
module line_density_mon #(
    parameter int unsigned MIN_ONES = pdm_pkg::PDM_MIN_ONES,
    parameter int unsigned ZRUN_MAX = pdm_pkg::PDM_ZRUN_MAX
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic chg_mode,
    input  logic stat_rd,
    output logic dens_state,
    output logic dens_status,
    output logic dens_irq
);
    logic run_viol_nxt, dens_viol_nxt, viol_nxt, viol_q;

    pdm_zero_run #(.ZRUN_MAX(ZRUN_MAX)) i_zero_run (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_vld      (bit_vld),
        .bit_in       (bit_in),
        .run_viol_nxt (run_viol_nxt)
    );

    pdm_window #(.MIN_ONES(MIN_ONES)) i_window (
        .clk           (clk),
        .rst_n         (rst_n),
        .bit_vld       (bit_vld),
        .bit_in        (bit_in),
        .dens_viol_nxt (dens_viol_nxt)
    );

    assign viol_nxt = run_viol_nxt || dens_viol_nxt;

    // Live state register, advanced only with a valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)       viol_q <= 1'b0;
        else if (bit_vld) viol_q <= viol_nxt;
    end

    pdm_irq_latch i_irq_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_vld  (bit_vld),
        .chg_mode (chg_mode),
        .viol_cur (viol_q),
        .viol_nxt (viol_nxt),
        .stat_rd  (stat_rd),
        .status   (dens_status)
    );

    assign dens_state = viol_q;
    assign dens_irq   = dens_status;

    // R6: the live state holds through cycles without a valid bit.
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(dens_state));
    // R2: a zero-run violation always reaches the live state.
    a_r2_run_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && run_viol_nxt) |=> dens_state);
endmodule

// File: tb/test_line_density_mon.sv
`timescale 1ns/1ps
// Directed bench for the line pulse density monitor with a behavioural model.
module test_line_density_mon;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0, bit_in = 1'b0, chg_mode = 1'b0, stat_rd = 1'b0;
    logic dens_state, dens_status, dens_irq;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Model state
    logic [191:0] m_hist;
    int m_seen, m_zrun;
    bit m_state, m_stat;

    always #2.5 clk = ~clk;

    line_density_mon i_line_density_mon (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .chg_mode(chg_mode), .stat_rd(stat_rd),
        .dens_state(dens_state), .dens_status(dens_status), .dens_irq(dens_irq)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "dens_state", dens_state, m_state);
        check(tag, "dens_status", dens_status, m_stat);
        check("R10", "dens_irq", dens_irq, m_stat);
    endtask

    // Drive one cycle, advance the model, compare after the edge.
    task automatic drive(input logic v, input logic b, input logic r, input string tag);
        bit nxt, setev;
        @(negedge clk);
        bit_vld = v; bit_in = b; stat_rd = r;
        @(posedge clk);
        #1;
        nxt = m_state;
        if (v) begin
            if (b) m_zrun = 0; else if (m_zrun < 100000) m_zrun++;
            m_hist = {m_hist[190:0], b};
            if (m_seen < 192) m_seen++;
            nxt = (m_zrun > 15) || (m_seen >= 192 && $countones(m_hist) < 23);
        end
        setev = v && (nxt != m_state) && (chg_mode || nxt);
        if (setev) m_stat = 1'b1; else if (r) m_stat = 1'b0;
        m_state = nxt;
        check_all(tag);
        bit_vld = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b0; stat_rd = 1'b0; chg_mode = mode;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_hist = '0; m_seen = 0; m_zrun = 0; m_state = 1'b0; m_stat = 1'b0;
        check_all("R1");
    endtask

    task automatic t_zero_run;
        do_reset(1'b0);
        repeat (15) drive(1, 0, 0, "R2");
        check("R2", "state after 15 zeros", dens_state, 1'b0);
        drive(1, 0, 0, "R2");
        check("R2", "state after 16 zeros", dens_state, 1'b1);
        check("R8", "status on entry", dens_status, 1'b1);
        drive(0, 0, 1, "R9");
        check("R9", "status after read", dens_status, 1'b0);
        drive(1, 1, 0, "R3");
        check("R3", "state after a one", dens_state, 1'b0);
        check("R8", "no status on exit", dens_status, 1'b0);
    endtask

    task automatic t_saturate;
        do_reset(1'b0);
        for (int i = 0; i < 60; i++) drive(1, 0, 0, "R3");
        check("R3", "state after 60 zeros", dens_state, 1'b1);
        drive(1, 1, 0, "R3");
        check("R3", "one ends long run", dens_state, 1'b0);
        repeat (15) drive(1, 0, 0, "R3");
        check("R3", "15 zeros after one", dens_state, 1'b0);
    endtask

    task automatic t_invalid_ignored;
        do_reset(1'b0);
        repeat (15) drive(1, 0, 0, "R6");
        repeat (20) drive(0, 0, 0, "R6");
        check("R6", "invalid zeros ignored", dens_state, 1'b0);
        drive(1, 0, 0, "R6");
        check("R6", "16th valid zero", dens_state, 1'b1);
        repeat (10) drive(0, 1, 0, "R6");
        check("R6", "invalid ones ignored", dens_state, 1'b1);
    endtask

    task automatic t_window_ok;
        do_reset(1'b1);
        for (int i = 0; i < 400; i++) drive(1, (i % 8) == 0, 0, "R4");
        check("R4", "24 ones per window", dens_state, 1'b0);
        check("R4", "no status at 24 ones", dens_status, 1'b0);
    endtask

    task automatic t_window_exact;
        // 23 ones at 0,8..176 then 15 zeros: exactly 23 ones, no violation.
        do_reset(1'b0);
        for (int i = 0; i < 192; i++) drive(1, (i % 8) == 0 && i <= 176, 0, "R4");
        check("R4", "exactly 23 ones", dens_state, 1'b0);
        drive(1, 1, 0, "R4");
        check("R4", "slide drops first one", dens_state, 1'b0);
    endtask

    task automatic t_window_fill;
        do_reset(1'b0);
        for (int i = 0; i < 191; i++) drive(1, (i % 9) == 0, 0, "R5");
        check("R5", "191 bits, window not applied", dens_state, 1'b0);
        drive(1, 0, 0, "R4");
        check("R4", "192 bits with 22 ones", dens_state, 1'b1);
        check("R8", "entry sets status", dens_status, 1'b1);
    endtask

    task automatic t_sliding;
        logic [15:0] lfsr = 16'hACE1;
        do_reset(1'b1);
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(1, (lfsr[2:0] == 3'd0) || (lfsr[6:0] == 7'd9), (i % 37) == 0, "R4");
        end
    endtask

    task automatic t_change_mode;
        do_reset(1'b1);
        repeat (16) drive(1, 0, 0, "R7");
        check("R7", "status on entry", dens_status, 1'b1);
        drive(0, 0, 1, "R9");
        check("R9", "cleared by read", dens_status, 1'b0);
        drive(1, 1, 0, "R7");
        check("R7", "status on exit", dens_status, 1'b1);
    endtask

    task automatic t_set_wins;
        do_reset(1'b1);
        repeat (15) drive(1, 0, 0, "R9");
        drive(1, 0, 1, "R9");
        check("R9", "set beats read", dens_status, 1'b1);
        drive(1, 0, 1, "R9");
        check("R9", "read with no event", dens_status, 1'b0);
    endtask

    initial begin
        t_zero_run();
        t_saturate();
        t_invalid_ignored();
        t_window_ok();
        t_window_exact();
        t_window_fill();
        t_sliding();
        t_change_mode();
        t_set_wins();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule